// File: doc/BRIEF.md
# Mixed-Security Banked Register Gate

This block is the register front-end of a peripheral that owns a set of per-resource controls, such as interrupt lines, pins or event channels. Each resource can be handed to either a secure or a non-secure software domain, and each is assigned on its own. The block holds three registers, one bit per resource in each. The first is an enable register. The second is a configuration register. The third is a domain mask; a set bit in the mask hands that resource to the non-secure domain.

A static mode input chooses how the block behaves. In secured mode the registers appear at two aliases, and one address bit selects between them. The secure alias has full access. The non-secure alias sees only the bits of resources that the mask hands over, and it cannot change the mask. An access to the secure alias without the security attribute is refused. In open mode the block applies no filtering: both aliases reach every bit, and no access is refused. Accesses use a single-cycle bus. Read data and the violation pulse are registered and appear one cycle after the request.

Top module: `sec_bank_gate`

## Requirements
- R1: After reset, the enable, configuration and mask registers are all zero, read data is zero and the violation output is low. Every resource therefore starts in the secure domain.
- R2: Address bit 2 selects the alias: 0 is secure and 1 is non-secure. Bits 1:0 select the register: 0 is enable, 1 is configuration, 2 is the mask. In secured mode (open_i = 0), an access to the secure alias with sec_i = 1 reads and writes every bit of any register.
- R3: In secured mode, an access to the secure alias with sec_i = 0 is refused. On the cycle after the request it returns zero read data and raises viol_o for exactly one cycle. A refused write changes no register.
- R4: Through the non-secure alias, an enable or configuration bit whose mask bit is 0 reads as 0 and ignores writes. A bit whose mask bit is 1 reads and writes normally within the same word. Each resource is handled independently of the others.
- R5: Through the non-secure alias, the mask register reads its full value, and writes to it have no effect.
- R6: In open mode (open_i = 1), every access to either alias, with any sec_i, reaches all bits of all three registers, the mask included. viol_o stays low.
- R7: Register index 3 is unmapped. It reads as zero, ignores writes and raises no violation.
- R8: Read data for an accepted read appears on the cycle after the request. In every other cycle rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| open_i | input | 1 | Static mode: 1 = open (no filtering), 0 = secured |
| req_i | input | 1 | Access request, valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| sec_i | input | 1 | Security attribute of the access |
| addr_i | input | 3 | Bit 2 = alias select, bits 1:0 = register index |
| wdata_i | input | N_RES | Write data, one bit per resource |
| rdata_o | output | N_RES | Registered read data |
| viol_o | output | 1 | One-cycle access-violation pulse |
| res_en_o | output | N_RES | Per-resource enable controls |
| res_cfg_o | output | N_RES | Per-resource configuration controls |
| res_ns_o | output | N_RES | Per-resource domain mask (1 = non-secure) |

## Verification
The assertions treat open_i as static: they assume it changes only while reset is asserted. The bench follows this rule and changes the mode only between reset pulses. The assertions also assume the bus inputs are free of X while rst_ni is high. The bench drives every bus input on the falling edge and holds a defined idle value between accesses. It sweeps all 256 mask values against write patterns that depend on the mask, and it checks each result against a model that the bench computes bit by bit.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_CFG  = 2'd1,
    REG_MASK = 2'd2,
    REG_NONE = 2'd3
  } sbg_reg_e;

  typedef struct packed {
    logic     ok;        // accepted access
    logic     refused;   // secure alias hit without attribute
    logic     filtered;  // non-secure alias in secured mode
    sbg_reg_e sel;
  } sbg_acc_t;
endpackage

// File: rtl/sbg_decode.sv
module sbg_decode
  import sbg_pkg::*;
(
  input  logic              req_i,
  input  logic              open_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] addr_i,
  output sbg_acc_t          acc_o
);
  logic ns_alias;

  always_comb begin
    ns_alias         = addr_i[ADDR_W-1];
    acc_o.sel        = sbg_reg_e'(addr_i[1:0]);
    acc_o.refused    = req_i && !open_i && !ns_alias && !sec_i;
    acc_o.filtered   = !open_i && ns_alias;
    acc_o.ok         = req_i && !acc_o.refused;
  end
endmodule

// File: rtl/sbg_regfile.sv
module sbg_regfile #(
  parameter int unsigned N_RES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_cfg_i,
  input  logic             wr_mask_i,
  input  logic [N_RES-1:0] wmask_i,
  input  logic [N_RES-1:0] wdata_i,
  output logic [N_RES-1:0] en_q_o,
  output logic [N_RES-1:0] cfg_q_o,
  output logic [N_RES-1:0] ns_q_o
);
  for (genvar g = 0; g < N_RES; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q_o[g]  <= 1'b0;
        cfg_q_o[g] <= 1'b0;
        ns_q_o[g]  <= 1'b0;
      end else begin
        if (wr_en_i && wmask_i[g])  en_q_o[g]  <= wdata_i[g];
        if (wr_cfg_i && wmask_i[g]) cfg_q_o[g] <= wdata_i[g];
        if (wr_mask_i)              ns_q_o[g]  <= wdata_i[g];
      end
    end
  end

  // R4: bits outside the write mask keep their value
  a_r4_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || wr_cfg_i) |=>
      (((en_q_o ^ $past(en_q_o)) | (cfg_q_o ^ $past(cfg_q_o))) & ~$past(wmask_i)) == '0);

  a_r4_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i || wr_cfg_i || wr_mask_i) |=>
      $stable(en_q_o) && $stable(cfg_q_o) && $stable(ns_q_o));
endmodule

// File: rtl/sec_bank_gate.sv
module sec_bank_gate
  import sbg_pkg::*;
#(
  parameter int unsigned N_RES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_RES-1:0]  wdata_i,
  output logic [N_RES-1:0]  rdata_o,
  output logic              viol_o,
  output logic [N_RES-1:0]  res_en_o,
  output logic [N_RES-1:0]  res_cfg_o,
  output logic [N_RES-1:0]  res_ns_o
);
  sbg_acc_t         acc;
  logic             wr, wr_en, wr_cfg, wr_mask;
  logic [N_RES-1:0] wmask, raw, rdata_d;

  sbg_decode i_decode (
    .req_i  (req_i),
    .open_i (open_i),
    .sec_i  (sec_i),
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  always_comb begin
    wr      = acc.ok && we_i;
    wr_en   = wr && (acc.sel == REG_EN);
    wr_cfg  = wr && (acc.sel == REG_CFG);
    wr_mask = wr && (acc.sel == REG_MASK) && !acc.filtered;
    wmask   = acc.filtered ? res_ns_o : '1;
  end

  sbg_regfile #(.N_RES(N_RES)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_cfg_i  (wr_cfg),
    .wr_mask_i (wr_mask),
    .wmask_i   (wmask),
    .wdata_i   (wdata_i),
    .en_q_o    (res_en_o),
    .cfg_q_o   (res_cfg_o),
    .ns_q_o    (res_ns_o)
  );

  always_comb begin
    unique case (acc.sel)
      REG_EN:   raw = res_en_o;
      REG_CFG:  raw = res_cfg_o;
      REG_MASK: raw = res_ns_o;
      default:  raw = '0;
    endcase
    if (acc.filtered && acc.sel != REG_MASK) raw = raw & res_ns_o;
    rdata_d = (acc.ok && !we_i) ? raw : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      viol_o  <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      viol_o  <= acc.refused;
    end
  end

  a_r3_viol_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> rdata_o == '0);

  a_r3_refused_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc.refused |=> $stable(res_en_o) && $stable(res_cfg_o) && $stable(res_ns_o));

  a_r5_ns_mask_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc.filtered) |=> $stable(res_ns_o));

  a_r6_open_no_viol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |-> !viol_o);

  a_r8_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> rdata_o == '0);
endmodule

// File: tb/test_sec_bank_gate.sv
module test_sec_bank_gate;
  localparam int unsigned N = 8;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, open_m = 1'b0;
  logic req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [2:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata, en_o, cfg_o, ns_o;
  logic viol;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  sec_bank_gate #(.N_RES(N)) i_sec_bank_gate (
    .clk_i(clk), .rst_ni(rst_n), .open_i(open_m), .req_i(req), .we_i(we),
    .sec_i(sec), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .viol_o(viol),
    .res_en_o(en_o), .res_cfg_o(cfg_o), .res_ns_o(ns_o)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // starts and ends on a falling edge; results are sampled one cycle later
  task automatic acc(input logic w, input logic al, input logic [1:0] ix,
                     input logic [N-1:0] d, input logic s,
                     output logic [N-1:0] rd, output logic v);
    req = 1'b1; we = w; addr = {al, ix}; wdata = d; sec = s;
    @(negedge clk);
    rd = rdata; v = viol;
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0; sec = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; open_m = mode;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] rd, p, d, e;
    logic v;
    do_reset(1'b0);
    // R1
    chk("R1 en", en_o, '0); chk("R1 cfg", cfg_o, '0); chk("R1 ns", ns_o, '0);
    chk("R1 rdata", rdata, '0); chk("R1 viol", {7'b0, viol}, '0);

    // R2/R4/R5 sweep over every mask value
    for (int m = 0; m < 256; m++) begin
      p = 8'((m * 37 + 5) & 255);
      d = 8'((m * 91 + 13) & 255);
      acc(1'b1, 1'b0, 2'd2, 8'(m), 1'b1, rd, v);
      acc(1'b1, 1'b0, 2'd0, p, 1'b1, rd, v);
      acc(1'b1, 1'b0, 2'd1, ~p, 1'b1, rd, v);
      acc(1'b0, 1'b0, 2'd2, '0, 1'b1, rd, v);
      chk("R2 mask readback", rd, 8'(m));
      acc(1'b1, 1'b1, 2'd0, d, 1'b0, rd, v);
      acc(1'b1, 1'b1, 2'd1, ~d, 1'b1, rd, v);
      e = (p & ~8'(m)) | (d & 8'(m));
      acc(1'b0, 1'b0, 2'd0, '0, 1'b1, rd, v);
      chk("R4 en secure view", rd, e);
      acc(1'b0, 1'b1, 2'd0, '0, 1'b0, rd, v);
      chk("R4 en ns view", rd, e & 8'(m));
      chk("R4 cfg port", cfg_o, (~p & ~8'(m)) | (~d & 8'(m)));
      acc(1'b1, 1'b1, 2'd2, ~8'(m), 1'b0, rd, v);
      acc(1'b0, 1'b1, 2'd2, '0, 1'b0, rd, v);
      chk("R5 ns mask read", rd, 8'(m));
      chk("R5 mask port", ns_o, 8'(m));
    end

    // R3 refusal
    acc(1'b1, 1'b0, 2'd2, 8'hC3, 1'b1, rd, v);
    acc(1'b1, 1'b0, 2'd0, 8'h5A, 1'b1, rd, v);
    acc(1'b1, 1'b0, 2'd0, 8'hFF, 1'b0, rd, v);
    chk("R3 viol write", {7'b0, v}, 8'd1);
    chk("R3 rdata on write", rd, '0);
    @(negedge clk);
    chk("R3 viol one cycle", {7'b0, viol}, '0);
    acc(1'b1, 1'b0, 2'd2, 8'h00, 1'b0, rd, v);
    chk("R3 refused mask write", ns_o, 8'hC3);
    acc(1'b0, 1'b0, 2'd0, '0, 1'b0, rd, v);
    chk("R3 refused read data", rd, '0);
    chk("R3 refused read viol", {7'b0, v}, 8'd1);
    chk("R3 en unchanged", en_o, 8'h5A);

    // R7 unmapped
    acc(1'b1, 1'b0, 2'd3, 8'hFF, 1'b1, rd, v);
    chk("R7 write no viol", {7'b0, v}, '0);
    acc(1'b0, 1'b0, 2'd3, '0, 1'b1, rd, v);
    chk("R7 read zero", rd, '0);
    chk("R7 regs", {en_o ^ 8'h5A} | {ns_o ^ 8'hC3}, '0);

    // R8 idle and write cycles carry zero data
    acc(1'b1, 1'b0, 2'd0, 8'h5A, 1'b1, rd, v);
    chk("R8 write rdata", rd, '0);
    @(negedge clk);
    chk("R8 idle rdata", rdata, '0);

    // R6 open mode
    do_reset(1'b1);
    chk("R1 open reset", ns_o | en_o | cfg_o, '0);
    acc(1'b1, 1'b1, 2'd2, 8'h3C, 1'b0, rd, v);
    chk("R6 ns alias mask write", ns_o, 8'h3C);
    acc(1'b1, 1'b1, 2'd0, 8'hE7, 1'b0, rd, v);
    chk("R6 unfiltered write", en_o, 8'hE7);
    acc(1'b0, 1'b0, 2'd0, '0, 1'b0, rd, v);
    chk("R6 secure alias no attr read", rd, 8'hE7);
    chk("R6 no viol", {7'b0, v}, '0);
    acc(1'b0, 1'b1, 2'd1, '0, 1'b0, rd, v);
    chk("R6 cfg unfiltered", rd, '0);
    acc(1'b1, 1'b0, 2'd1, 8'h81, 1'b0, rd, v);
    acc(1'b0, 1'b1, 2'd1, '0, 1'b1, rd, v);
    chk("R6 cfg readback", rd, 8'h81);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule